// File: doc/BRIEF.md
# IDE PIO Command Strobe Timer

This block drives the active-low read and write command strobes of a parallel ATA/IDE channel. Timing is counted in cycles of the host bus clock. Two drives share the channel, and each has its own three timing registers: one for wide (16-bit) reads, one for wide writes, and one narrow (8-bit) command register that serves both directions. Each register holds an active field and a recovery field. The strobe lasts the active field plus one cycles and is then held off for the recovery field plus one cycles.

A host controller programs the registers through a simple write/read port. It then asks for a transfer with a one-bit request, qualified by the drive, the direction and the width. Each drive also has a PIO mode input. This input decides whether a narrow transfer takes the narrow register (slow modes) or the direction's wide register (fast modes). The request is taken only while the block is idle. The timing fields are captured when the request is taken, and `done` marks the last recovery cycle.

Top module: `ide_pio_strobe`

## Requirements
- R1: During and after reset `ior_n` and `iow_n` are high, `ready` is 1 and `done` is 0. Each drive's wide-read register reads 0x33, its wide-write register reads 0x6E and its narrow register reads 0xAA.
- R2: `cfg_addr[2]` selects the drive (0 master, 1 slave) and `cfg_addr[1:0]` selects the register: 0 wide read, 1 wide write, 2 narrow. A write takes effect at the clock edge and `cfg_rdata` shows the addressed register combinationally. Bits 7:4 are the active field and bits 3:0 are the recovery field.
- R3: A request taken at an edge pulls the selected strobe low from that edge for exactly active+1 cycles.
- R4: After the strobe rises it stays high for exactly recovery+1 cycles. `done` is 1 only on the last of those cycles, and `ready` returns on the next cycle.
- R5: `ready` is 1 only when no strobe or recovery is in progress. A request made while `ready` is 0 is ignored, and it does not start another strobe afterwards.
- R6: A wide transfer (`req_wide`=1) uses the wide register for its direction. A narrow transfer uses the narrow register when the drive's mode is 0, 1 or 2, and the wide register for its direction when the mode is 3 or 4.
- R7: `req_drive` selects both the register set and the mode input (`mode_master` or `mode_slave`) of the addressed drive.
- R8: Timing fields are captured when the request is taken. A register write during a transfer changes only later transfers.
- R9: A read (`req_write`=0) pulses only `ior_n` and a write pulses only `iow_n`. The two strobes are never low together.
- R10: Mode values 5 to 7 are treated like modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address {drive, select} |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Addressed register contents |
| mode_master | input | 3 | PIO mode of the master drive |
| mode_slave | input | 3 | PIO mode of the slave drive |
| req | input | 1 | Transfer request |
| req_drive | input | 1 | 0 master, 1 slave |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for 16-bit, 0 for 8-bit |
| ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Last recovery cycle |
| ior_n | output | 1 | Read command strobe, active low |
| iow_n | output | 1 | Write command strobe, active low |

## Verification
Every register is first loaded with a distinct value, so the measured active and recovery lengths show which register a transfer used. The same pattern with the mode on either side of the 2/3 boundary separates the narrow register from the wide one. The other drive always has the opposite mode class, which exposes a wrong drive-to-mode pairing. Field values of 0 and 15 probe the short and long ends of both counts. A write issued during a transfer, and a request held high through a transfer, show that timing is captured at the start and that requests made while busy are dropped.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_REC  = 2'd2
   } tim_state_t;

   localparam logic [1:0] SEL_RD_WIDE = 2'd0;
   localparam logic [1:0] SEL_WR_WIDE = 2'd1;
   localparam logic [1:0] SEL_NARROW  = 2'd2;
endpackage

// File: rtl/ide_tim_regs.sv
module ide_tim_regs
   import ide_tim_pkg::*;
#(
   parameter int unsigned FW = 4,
   parameter int unsigned RW = 2 * FW,
   parameter logic [RW-1:0] DEF_RD_M  = 8'h33,
   parameter logic [RW-1:0] DEF_WR_M  = 8'h6E,
   parameter logic [RW-1:0] DEF_NAR_M = 8'hAA,
   parameter logic [RW-1:0] DEF_RD_S  = 8'h33,
   parameter logic [RW-1:0] DEF_WR_S  = 8'h6E,
   parameter logic [RW-1:0] DEF_NAR_S = 8'hAA
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2:0]          addr,
   input  logic [RW-1:0]       wdata,
   output logic [RW-1:0]       rdata,
   output logic [1:0][RW-1:0]  rd_wide,
   output logic [1:0][RW-1:0]  wr_wide,
   output logic [1:0][RW-1:0]  narrow
);
   for (genvar gd = 0; gd < 2; gd++) begin : g_drv
      localparam logic [RW-1:0] D_RD  = (gd == 0) ? DEF_RD_M  : DEF_RD_S;
      localparam logic [RW-1:0] D_WR  = (gd == 0) ? DEF_WR_M  : DEF_WR_S;
      localparam logic [RW-1:0] D_NAR = (gd == 0) ? DEF_NAR_M : DEF_NAR_S;
      logic hit;
      assign hit = we && (addr[2] == gd[0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_wide[gd] <= D_RD;
            wr_wide[gd] <= D_WR;
            narrow[gd]  <= D_NAR;
         end else if (hit) begin
            case (addr[1:0])
               SEL_RD_WIDE: rd_wide[gd] <= wdata;
               SEL_WR_WIDE: wr_wide[gd] <= wdata;
               SEL_NARROW:  narrow[gd]  <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (addr[1:0])
         SEL_RD_WIDE: rdata = rd_wide[addr[2]];
         SEL_WR_WIDE: rdata = wr_wide[addr[2]];
         SEL_NARROW:  rdata = narrow[addr[2]];
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/ide_tim_pick.sv
module ide_tim_pick #(
   parameter int unsigned FW = 4,
   parameter int unsigned RW = 2 * FW,
   parameter int unsigned MW = 3,
   parameter int unsigned NARROW_MAX_MODE = 2
) (
   input  logic               drive,
   input  logic               write,
   input  logic               wide,
   input  logic [MW-1:0]      mode_m,
   input  logic [MW-1:0]      mode_s,
   input  logic [1:0][RW-1:0] rd_wide,
   input  logic [1:0][RW-1:0] wr_wide,
   input  logic [1:0][RW-1:0] narrow,
   output logic [FW-1:0]      pulse,
   output logic [FW-1:0]      recov
);
   logic [MW-1:0] md;
   logic          use_nar;
   logic [RW-1:0] chosen;

   always_comb begin
      md      = drive ? mode_s : mode_m;
      use_nar = !wide && (32'(md) <= NARROW_MAX_MODE);
      if (use_nar)    chosen = narrow[drive];
      else if (write) chosen = wr_wide[drive];
      else            chosen = rd_wide[drive];
      pulse = chosen[RW-1:FW];
      recov = chosen[FW-1:0];
   end
endmodule

// File: rtl/ide_tim_seq.sv
module ide_tim_seq
   import ide_tim_pkg::*;
#(
   parameter int unsigned FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_write,
   input  logic [FW-1:0] pulse,
   input  logic [FW-1:0] recov,
   output logic          ready,
   output logic          done,
   output logic          ior_n,
   output logic          iow_n
);
   tim_state_t    st;
   logic [FW-1:0] cnt;
   logic [FW-1:0] rec_q;
   logic          wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         rec_q <= '0;
         wr_q  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               st    <= ST_ACT;
               cnt   <= pulse;
               rec_q <= recov;
               wr_q  <= req_write;
            end
            ST_ACT: if (cnt == '0) begin
               st  <= ST_REC;
               cnt <= rec_q;
            end else begin
               cnt <= cnt - 1'b1;
            end
            ST_REC: if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ready = (st == ST_IDLE);
   assign done  = (st == ST_REC) && (cnt == '0);
   assign ior_n = !((st == ST_ACT) && !wr_q);
   assign iow_n = !((st == ST_ACT) && wr_q);
endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe #(
   parameter int unsigned FW = 4,
   parameter int unsigned MW = 3,
   parameter int unsigned NARROW_MAX_MODE = 2,
   parameter logic [2*FW-1:0] DEF_RD_M  = 8'h33,
   parameter logic [2*FW-1:0] DEF_WR_M  = 8'h6E,
   parameter logic [2*FW-1:0] DEF_NAR_M = 8'hAA,
   parameter logic [2*FW-1:0] DEF_RD_S  = 8'h33,
   parameter logic [2*FW-1:0] DEF_WR_S  = 8'h6E,
   parameter logic [2*FW-1:0] DEF_NAR_S = 8'hAA
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_addr,
   input  logic [2*FW-1:0] cfg_wdata,
   output logic [2*FW-1:0] cfg_rdata,
   input  logic [MW-1:0]   mode_master,
   input  logic [MW-1:0]   mode_slave,
   input  logic            req,
   input  logic            req_drive,
   input  logic            req_write,
   input  logic            req_wide,
   output logic            ready,
   output logic            done,
   output logic            ior_n,
   output logic            iow_n
);
   localparam int unsigned RW = 2 * FW;

   if (FW < 2 || FW > 8) begin : g_bad_fw
      $error("ide_pio_strobe: FW must be in 2..8");
   end
   if (NARROW_MAX_MODE >= (1 << MW)) begin : g_bad_mode
      $error("ide_pio_strobe: NARROW_MAX_MODE does not fit MW");
   end

   logic [1:0][RW-1:0] rd_wide, wr_wide, narrow;
   logic [FW-1:0]      pulse, recov;

   ide_tim_regs #(
      .FW(FW), .RW(RW),
      .DEF_RD_M(DEF_RD_M), .DEF_WR_M(DEF_WR_M), .DEF_NAR_M(DEF_NAR_M),
      .DEF_RD_S(DEF_RD_S), .DEF_WR_S(DEF_WR_S), .DEF_NAR_S(DEF_NAR_S)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .rd_wide(rd_wide), .wr_wide(wr_wide), .narrow(narrow)
   );

   ide_tim_pick #(
      .FW(FW), .RW(RW), .MW(MW), .NARROW_MAX_MODE(NARROW_MAX_MODE)
   ) u_pick (
      .drive(req_drive), .write(req_write), .wide(req_wide),
      .mode_m(mode_master), .mode_s(mode_slave),
      .rd_wide(rd_wide), .wr_wide(wr_wide), .narrow(narrow),
      .pulse(pulse), .recov(recov)
   );

   ide_tim_seq #(.FW(FW)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
      .pulse(pulse), .recov(recov),
      .ready(ready), .done(done), .ior_n(ior_n), .iow_n(iow_n)
   );
endmodule

// File: rtl/ide_pio_strobe_chk.sv
module ide_pio_strobe_chk (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic ready,
   input logic done,
   input logic ior_n,
   input logic iow_n
);
   always_comb begin
      if (!rst_n) begin
         a_reset_high_r1: assert (ior_n && iow_n && ready && !done);
      end
   end

   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ior_n && !iow_n));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ior_n && iow_n && !done));

   p_done_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ready);

   p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ior_n && iow_n));

   p_ior_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ior_n) |-> $past(req && ready));

   p_iow_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iow_n) |-> $past(req && ready));
endmodule

bind ide_pio_strobe ide_pio_strobe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
   .done(done), .ior_n(ior_n), .iow_n(iow_n)
);

// File: tb/ide_pio_strobe_bench.sv
module ide_pio_strobe_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [2:0] mode_master = '0, mode_slave = '0;
   logic       req = 1'b0, req_drive = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic       ready, done, ior_n, iow_n;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   ide_pio_strobe u_ide_pio_strobe (.*);

   // {drive, write, wide, mode[2:0], active[3:0], recovery[3:0]}
   localparam logic [13:0] VEC [9] = '{
      {1'b0, 1'b0, 1'b1, 3'd0, 4'd2, 4'd1},  // R6 wide read master
      {1'b0, 1'b1, 1'b1, 3'd4, 4'd4, 4'd3},  // R6 wide write master
      {1'b0, 1'b0, 1'b0, 3'd1, 4'd1, 4'd5},  // R6 narrow read slow mode
      {1'b0, 1'b1, 1'b0, 3'd2, 4'd1, 4'd5},  // R6 narrow write slow mode
      {1'b0, 1'b0, 1'b0, 3'd3, 4'd2, 4'd1},  // R6 narrow fast mode
      {1'b1, 1'b0, 1'b1, 3'd0, 4'd5, 4'd2},  // R7 slave wide read
      {1'b1, 1'b1, 1'b0, 3'd0, 4'd3, 4'd0},  // R7 slave narrow
      {1'b1, 1'b1, 1'b0, 3'd4, 4'd0, 4'd7},  // R7 slave narrow fast
      {1'b1, 1'b0, 1'b0, 3'd6, 4'd5, 4'd2}   // R10 mode 6
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_check(input logic [2:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(cfg_rdata === e, tag, int'(cfg_rdata), int'(e));
   endtask

   task automatic run_xfer(input bit drv, input bit wr, input bit wide,
                           input int ep, input int er, input int hold, input string tag);
      int lo = 0, rc = 0, di = -1, bad = 0, h = hold;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; req_drive = drv; req_write = wr; req_wide = wide;
      @(negedge clk);
      if (h == 0) req = 1'b0;
      while (((wr ? iow_n : ior_n) == 1'b0) && lo < 40) begin
         lo++;
         if ((wr ? ior_n : iow_n) == 1'b0) bad++;
         @(negedge clk);
         if (h > 0) h--;
         if (h == 0) req = 1'b0;
      end
      check(lo == ep + 1, {tag, " R3 active cycles"}, lo, ep + 1);
      while (!ready && rc < 40) begin
         if (done) di = (di >= 0) ? 99 : rc;
         if (!ior_n || !iow_n) bad++;
         rc++;
         @(negedge clk);
         if (h > 0) h--;
         if (h == 0) req = 1'b0;
      end
      req = 1'b0;
      check(rc == er + 1, {tag, " R4 recovery cycles"}, rc, er + 1);
      check(di == er, {tag, " R4 done position"}, di, er);
      check(bad == 0, {tag, " R9 other strobe quiet"}, bad, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1;
      check(ior_n && iow_n, "R1 strobes high in reset", int'({ior_n, iow_n}), 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready === 1'b1 && done === 1'b0, "R1 idle after reset", int'({ready, done}), 2);
      check(ior_n && iow_n, "R1 strobes high after reset", int'({ior_n, iow_n}), 3);
      cfg_check(3'd0, 8'h33, "R1 master wide read default");
      cfg_check(3'd1, 8'h6E, "R1 master wide write default");
      cfg_check(3'd2, 8'hAA, "R1 master narrow default");
      cfg_check(3'd4, 8'h33, "R1 slave wide read default");
      cfg_check(3'd5, 8'h6E, "R1 slave wide write default");
      cfg_check(3'd6, 8'hAA, "R1 slave narrow default");

      // reserved slot: write ignored, reads zero
      cfg_write(3'd3, 8'h5A);
      cfg_check(3'd3, 8'h00, "R2 reserved reads zero");
      cfg_check(3'd0, 8'h33, "R2 reserved write leaves others");

      // default timing: master wide write 6/14
      run_xfer(1'b0, 1'b1, 1'b1, 6, 14, 0, "R1 default timing");

      cfg_write(3'd0, 8'h21); cfg_write(3'd1, 8'h43); cfg_write(3'd2, 8'h15);
      cfg_write(3'd4, 8'h52); cfg_write(3'd5, 8'h07); cfg_write(3'd6, 8'h30);
      cfg_check(3'd2, 8'h15, "R2 readback master narrow");
      cfg_check(3'd5, 8'h07, "R2 readback slave wide write");

      for (int i = 0; i < 9; i++) begin
         logic [13:0] v = VEC[i];
         logic [2:0] other = (v[10:8] <= 3'd2) ? 3'd4 : 3'd0;
         if (v[13]) begin mode_slave = v[10:8]; mode_master = other; end
         else       begin mode_master = v[10:8]; mode_slave = other; end
         run_xfer(v[13], v[12], v[11], int'(v[7:4]), int'(v[3:0]), 0,
                  $sformatf("R6 R7 vector %0d", i));
      end

      // R8: write during a transfer takes effect on the next one
      mode_master = 3'd0;
      fork
         run_xfer(1'b0, 1'b0, 1'b1, 2, 1, 0, "R8 latched old value");
         begin
            repeat (2) @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h00;
            @(negedge clk);
            cfg_we = 1'b0;
         end
      join
      run_xfer(1'b0, 1'b0, 1'b1, 0, 0, 0, "R8 new value next transfer");

      // longest fields
      cfg_write(3'd5, 8'hFF);
      run_xfer(1'b1, 1'b1, 1'b1, 15, 15, 0, "R3 R4 max fields");

      // R5: request held through a busy transfer is dropped
      run_xfer(1'b1, 1'b1, 1'b1, 15, 15, 6, "R5 held request");
      begin
         int busy = 0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!ior_n || !iow_n || !ready) busy++;
         end
         check(busy == 0, "R5 no strobe from request made while busy", busy, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule